// File: doc/BRIEF.md
# Shared-Pin GPIO Port with Priority Function Select

This block is an eight-pin general-purpose I/O port whose pins are also offered to two on-chip peripherals: a PWM engine with one channel per pin and two SPI engines with four signals each. For every pin a fixed priority picks the owner. An enabled PWM channel wins. If that channel is off and the SPI engine routed to the pin is enabled, the SPI engine owns it. Otherwise the pin is plain GPIO, driven from a data register and a direction register. The PWM and SPI engines are outside this block. It takes only their output values, output enables and enable flags, and it returns the synchronized pin levels to the SPI side.

Software uses a small register bus with two locations. The direction location holds one bit per pin, where 1 means output. The data location holds the output value. A data read mixes its sources bit by bit. Pins set as outputs return the stored bit. Pins set as inputs return the pin level after synchronization. Pad drive, pull and slew control belong to the pad ring and are not part of this block.

The pin outputs, the output enables and the read data are all registered. Each of them therefore reflects the inputs and the state from the clock edge before.

Top module: `altpin_port`

## Requirements
- R1: After a synchronous reset, the data register and the direction register are all zeros, pin_oe is all zeros and bus_rdata is zero.
- R2: When bus_wr is 1 at a clock edge, bus_wdata is written to the data register if bus_addr is 0, or to the direction register if bus_addr is 1. Writes are accepted in every cycle. When bus_addr is 1, bus_rdata shows the direction register as it was at the previous edge, one cycle after the address is presented.
- R3: When pwm_en[n] is 1, pin n is an output one cycle later (pin_oe[n]=1) and pin_out[n] equals pwm_out[n]. This holds whatever the SPI enables and the direction register contain.
- R4: Pins 0 to 3 belong to SPI group 0 and pins 4 to 7 belong to SPI group 1. Within group 1, pins 7, 6, 5 and 4 carry clock, select, MOSI and MISO. Within group 0, pins 3, 2, 1 and 0 carry select, clock, MOSI and MISO. When pwm_en[n] is 0 and spi_en of pin n's group is 1, the next cycle gives pin_oe[n]=spi_oe[n] and pin_out[n]=spi_do[n].
- R5: When neither function claims pin n, the next cycle gives pin_oe[n] equal to direction bit n and pin_out[n] equal to data bit n.
- R6: When bus_addr is 0, bus_rdata bit n shows, one cycle later, data bit n if direction bit n is 1, or the synchronized level of pin n if direction bit n is 0.
- R7: pin_in passes through a two-flop synchronizer. A level applied before edge k appears on spi_di after edge k+1, and it affects a data read from edge k+2 on.
- R8: A data write made while PWM or SPI owns a pin is kept. That pin drives the written value once it returns to GPIO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 selects data, 1 selects direction |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pwm_en | input | 8 | Per-pin PWM channel enable |
| pwm_out | input | 8 | Per-pin PWM output value |
| spi_en | input | 2 | Enable of SPI group 0 (pins 0-3) and group 1 (pins 4-7) |
| spi_do | input | 8 | Per-pin SPI output value |
| spi_oe | input | 8 | Per-pin SPI output enable |
| spi_di | output | 8 | Synchronized pin levels for the SPI engines |
| pin_in | input | 8 | Raw pin levels from the pads |
| pin_out | output | 8 | Registered pin output values |
| pin_oe | output | 8 | Registered pin output enables |

## Verification
Random enable patterns drive each pin through all three owners in many combinations. This separates PWM-over-SPI priority from SPI-over-GPIO priority, and each SPI group enable is confirmed to reach only its own four pins. Random direction masks combined with changing pin levels show whether a data read chooses its source bit by bit, and they expose any error in the synchronizer depth. Directed sequences cover the reset state, writes made while PWM holds every pin (these must appear once PWM releases the pins), and a single pin step that is timed through the synchronizer.

// File: rtl/altpin_pkg.sv
package altpin_pkg;
  localparam int ADDR_W = 1;
  localparam logic [ADDR_W-1:0] LOC_DATA = 1'b0;
  localparam logic [ADDR_W-1:0] LOC_DIR  = 1'b1;

  typedef enum logic [1:0] {
    OWN_GPIO = 2'd0,
    OWN_SPI  = 2'd1,
    OWN_PWM  = 2'd2
  } owner_e;

  function automatic owner_e pick_owner(input logic pwm_on, input logic spi_on);
    if (pwm_on)      return OWN_PWM;
    else if (spi_on) return OWN_SPI;
    else             return OWN_GPIO;
  endfunction
endpackage

// File: rtl/altpin_sync.sv
module altpin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= async_in;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[k] <= '0;
      else     chain[k] <= chain[k-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/altpin_regs.sv
module altpin_regs
  import altpin_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic [WIDTH-1:0]  pin_lvl,
  output logic [WIDTH-1:0]  data_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  bus_rdata
);
  logic wr_data, wr_dir;
  logic [WIDTH-1:0] data_view;
  logic [WIDTH-1:0] rd_next;

  assign wr_data = bus_wr && (bus_addr == LOC_DATA);
  assign wr_dir  = bus_wr && (bus_addr == LOC_DIR);

  // data register: stored regardless of which source owns each pin
  always_ff @(posedge clk) begin
    if (rst)          data_q <= '0;
    else if (wr_data) data_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)         dir_q <= '0;
    else if (wr_dir) dir_q <= bus_wdata;
  end

  // per-bit read source: stored bit for outputs, pin level for inputs
  for (genvar i = 0; i < WIDTH; i++) begin : g_view
    assign data_view[i] = dir_q[i] ? data_q[i] : pin_lvl[i];
  end

  always_comb begin
    unique case (bus_addr)
      LOC_DIR: rd_next = dir_q;
      default: rd_next = data_view;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/altpin_pinmux.sv
module altpin_pinmux
  import altpin_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int SPI_GROUPS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [WIDTH-1:0]      data_q,
  input  logic [WIDTH-1:0]      dir_q,
  input  logic [WIDTH-1:0]      pwm_en,
  input  logic [WIDTH-1:0]      pwm_out,
  input  logic [SPI_GROUPS-1:0] spi_en,
  input  logic [WIDTH-1:0]      spi_do,
  input  logic [WIDTH-1:0]      spi_oe,
  output logic [WIDTH-1:0]      pin_out,
  output logic [WIDTH-1:0]      pin_oe
);
  localparam int GROUP_PINS = WIDTH / SPI_GROUPS;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    localparam int GRP = i / GROUP_PINS;
    owner_e owner;
    logic   out_nx, oe_nx;

    assign owner = pick_owner(pwm_en[i], spi_en[GRP]);

    always_comb begin
      unique case (owner)
        OWN_PWM: begin out_nx = pwm_out[i]; oe_nx = 1'b1;      end
        OWN_SPI: begin out_nx = spi_do[i];  oe_nx = spi_oe[i]; end
        default: begin out_nx = data_q[i];  oe_nx = dir_q[i];  end
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out[i] <= 1'b0;
        pin_oe[i]  <= 1'b0;
      end else begin
        pin_out[i] <= out_nx;
        pin_oe[i]  <= oe_nx;
      end
    end
  end
endmodule

// File: rtl/altpin_port.sv
module altpin_port
  import altpin_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SPI_GROUPS  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [PORT_W-1:0]     bus_wdata,
  output logic [PORT_W-1:0]     bus_rdata,
  input  logic [PORT_W-1:0]     pwm_en,
  input  logic [PORT_W-1:0]     pwm_out,
  input  logic [SPI_GROUPS-1:0] spi_en,
  input  logic [PORT_W-1:0]     spi_do,
  input  logic [PORT_W-1:0]     spi_oe,
  output logic [PORT_W-1:0]     spi_di,
  input  logic [PORT_W-1:0]     pin_in,
  output logic [PORT_W-1:0]     pin_out,
  output logic [PORT_W-1:0]     pin_oe
);
  logic [PORT_W-1:0] pin_lvl;
  logic [PORT_W-1:0] data_q;
  logic [PORT_W-1:0] dir_q;

  altpin_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (pin_lvl)
  );

  assign spi_di = pin_lvl;

  altpin_regs #(.WIDTH(PORT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_lvl   (pin_lvl),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .bus_rdata (bus_rdata)
  );

  altpin_pinmux #(.WIDTH(PORT_W), .SPI_GROUPS(SPI_GROUPS)) u_mux (
    .clk     (clk),
    .rst     (rst),
    .data_q  (data_q),
    .dir_q   (dir_q),
    .pwm_en  (pwm_en),
    .pwm_out (pwm_out),
    .spi_en  (spi_en),
    .spi_do  (spi_do),
    .spi_oe  (spi_oe),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );
endmodule

// File: rtl/altpin_port_chk.sv
module altpin_port_chk
  import altpin_pkg::*;
#(
  parameter int PORT_W     = 8,
  parameter int SPI_GROUPS = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_wr,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [PORT_W-1:0]     bus_wdata,
  input logic [PORT_W-1:0]     bus_rdata,
  input logic [PORT_W-1:0]     pwm_en,
  input logic [PORT_W-1:0]     pwm_out,
  input logic [SPI_GROUPS-1:0] spi_en,
  input logic [PORT_W-1:0]     spi_do,
  input logic [PORT_W-1:0]     spi_oe,
  input logic [PORT_W-1:0]     pin_out,
  input logic [PORT_W-1:0]     pin_oe,
  input logic [PORT_W-1:0]     data_q,
  input logic [PORT_W-1:0]     dir_q,
  input logic [PORT_W-1:0]     pin_lvl
);
  localparam int GROUP_PINS = PORT_W / SPI_GROUPS;

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == LOC_DIR) |=> dir_q == $past(bus_wdata));

  assert_data_write_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == LOC_DATA) |=> data_q == $past(bus_wdata));

  assert_read_mix_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == LOC_DATA) |=>
      bus_rdata == $past((dir_q & data_q) | (~dir_q & pin_lvl)));

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    localparam int GRP = i / GROUP_PINS;

    assert_pwm_wins_R3: assert property (@(posedge clk) disable iff (rst)
      pwm_en[i] |=> (pin_oe[i] && pin_out[i] == $past(pwm_out[i])));

    assert_spi_owns_R4: assert property (@(posedge clk) disable iff (rst)
      (!pwm_en[i] && spi_en[GRP]) |=>
        (pin_oe[i] == $past(spi_oe[i]) && pin_out[i] == $past(spi_do[i])));

    assert_gpio_drive_R5: assert property (@(posedge clk) disable iff (rst)
      (!pwm_en[i] && !spi_en[GRP]) |=>
        (pin_oe[i] == $past(dir_q[i]) && pin_out[i] == $past(data_q[i])));
  end
endmodule

bind altpin_port altpin_port_chk #(.PORT_W(PORT_W), .SPI_GROUPS(SPI_GROUPS)) u_chk (.*);

// File: tb/altpin_port_tb.sv
module altpin_port_tb;
  localparam int W = 8;
  localparam int G = 2;

  logic clk = 1'b0;
  logic rst;
  logic bus_wr;
  logic bus_addr;
  logic [W-1:0] bus_wdata, bus_rdata;
  logic [W-1:0] pwm_en, pwm_out, spi_do, spi_oe, spi_di, pin_in, pin_out, pin_oe;
  logic [G-1:0] spi_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // independent model state
  logic [W-1:0] m_data, m_dir, m_s1, m_s2;
  logic [W-1:0] e_out, e_oe, e_rd, e_di;

  always #5 clk = ~clk;

  altpin_port u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_en(pwm_en),
    .pwm_out(pwm_out), .spi_en(spi_en), .spi_do(spi_do), .spi_oe(spi_oe),
    .spi_di(spi_di), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] read_view(input logic a);
    return a ? m_dir : ((m_dir & m_data) | (~m_dir & m_s2));
  endfunction

  // one clock: predict from pre-edge state, advance model, compare after edge
  task automatic step();
    for (int i = 0; i < W; i++) begin
      if (pwm_en[i]) begin
        e_out[i] = pwm_out[i]; e_oe[i] = 1'b1;
      end else if (spi_en[i / (W / G)]) begin
        e_out[i] = spi_do[i]; e_oe[i] = spi_oe[i];
      end else begin
        e_out[i] = m_data[i]; e_oe[i] = m_dir[i];
      end
    end
    e_rd = read_view(bus_addr);
    e_di = m_s1;
    m_s2 = m_s1;
    m_s1 = pin_in;
    if (bus_wr && !bus_addr) m_data = bus_wdata;
    if (bus_wr &&  bus_addr) m_dir  = bus_wdata;
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < W; i++) begin
      string tg;
      if (pwm_en[i]) tg = "R3 pwm owner";
      else if (spi_en[i / (W / G)]) tg = "R4 spi owner";
      else tg = "R5 gpio owner";
      check($sformatf("%s pin%0d out/oe", tg, i), {6'd0, pin_out[i], pin_oe[i]},
            {6'd0, e_out[i], e_oe[i]});
    end
    check(bus_addr ? "R2 dir readback" : "R6 data readback", bus_rdata, e_rd);
    check("R7 spi_di sync", spi_di, e_di);
  endtask

  task automatic idle_inputs();
    bus_wr = 0; bus_addr = 0; bus_wdata = '0; pwm_en = '0; pwm_out = '0;
    spi_en = '0; spi_do = '0; spi_oe = '0;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    idle_inputs();
    pin_in = 8'h3c;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_data = '0; m_dir = '0; m_s1 = '0; m_s2 = '0;

    // R1: reset state
    check("R1 pin_oe after reset", pin_oe, '0);
    check("R1 rdata after reset", bus_rdata, '0);
    bus_addr = 1; step();
    check("R1 direction reads zero", bus_rdata, '0);
    bus_wr = 1; bus_wdata = 8'hff; step();
    bus_wr = 0; bus_addr = 0; step();
    check("R1 data reads zero as outputs", bus_rdata, 8'h00);

    // R8: writes while PWM owns every pin, then release
    pwm_en = 8'hff; pwm_out = 8'h0f;
    bus_wr = 1; bus_wdata = 8'ha5; step();
    bus_wr = 0; step();
    check("R8 pwm still drives", pin_out, 8'h0f);
    pwm_en = '0; step();
    check("R8 written value after release", pin_out, 8'ha5);
    check("R8 all outputs", pin_oe, 8'hff);

    // R7: single pin step timing through synchronizer
    bus_wr = 1; bus_addr = 1; bus_wdata = 8'h00; step();
    bus_wr = 0; bus_addr = 0; pin_in = 8'h00; step(); step(); step();
    pin_in = 8'h01; step();
    check("R7 not yet on spi_di", spi_di, 8'h00);
    step();
    check("R7 on spi_di after two edges", spi_di, 8'h01);
    check("R7 read not yet updated", bus_rdata, 8'h00);
    step();
    check("R7 read updated after three edges", bus_rdata, 8'h01);

    // R4: group isolation directed
    spi_en = 2'b10; spi_do = 8'hf0; spi_oe = 8'hc0; step();
    check("R4 group1 only oe", pin_oe, 8'hc0);
    spi_en = 2'b01; spi_do = 8'h0a; spi_oe = 8'h03; step();
    check("R4 group0 only oe", pin_oe, 8'h03);

    // random mix
    for (int c = 0; c < 3000; c++) begin
      bus_wr    = ($urandom % 4) == 0;
      bus_addr  = $urandom % 2;
      bus_wdata = $urandom;
      pwm_en    = $urandom & $urandom;
      pwm_out   = $urandom;
      spi_en    = $urandom;
      spi_do    = $urandom;
      spi_oe    = $urandom;
      pin_in    = $urandom;
      step();
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule